// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block turns one 32-bit load/store instruction word, together with the current base register value and the value of the index register, into the address used for the memory access and the value to be written back into the base register. It decodes the instruction fields itself. From those fields it selects the offset source and the add or subtract direction. It then chooses between pre-indexed addressing, where the access uses the adjusted base, and post-indexed addressing, where the access uses the base unchanged and the adjusted base is written back.

The offset is either a 12-bit unsigned immediate or the index register value shifted left by a 5-bit amount. One shared adder/subtractor forms base plus or minus offset. The results are registered. A one-cycle valid pulse marks each accepted instruction, and the output fields hold their values between pulses.

Top module: `ls_addr_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `out_valid` and `wb_en` are 0, and `mem_addr` and `wb_val` are 0.
- R2: An instruction is accepted when `in_valid` is 1 and `insn[27:26]` equals 2'b01. `out_valid` is 1 for exactly the single cycle after an accepted instruction and is 0 after any cycle without one.
- R3: When `insn[25]` is 0, the offset is `insn[11:0]` zero-extended to 32 bits. When `insn[25]` is 1, the offset is `idx_val` shifted left by `insn[11:7]` bits, with the bits shifted out discarded.
- R4: When `insn[23]` is 1 the offset is added to `base_val`, and when it is 0 the offset is subtracted from it. Both are computed modulo 2^32.
- R5: Pre-indexed (`insn[24]`=1): `mem_addr` and `wb_val` both equal the adjusted base, and `wb_en` equals the writeback bit `insn[21]`.
- R6: Post-indexed (`insn[24]`=0): `mem_addr` equals `base_val` unchanged, `wb_val` equals the adjusted base, and `wb_en` is 1 whatever `insn[21]` holds.
- R7: In the pre-indexed case with writeback requested and a base register number `insn[19:16]` of 15, `wb_en` is 0.
- R8: An instruction that is not accepted has no effect: `mem_addr`, `wb_val` and `wb_en` keep the values from the last accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operands are present |
| insn | input | 32 | Load/store instruction word |
| base_val | input | 32 | Value of the base register named by insn[19:16] |
| idx_val | input | 32 | Value of the index register used for a register offset |
| out_valid | output | 1 | One-cycle pulse for each accepted instruction |
| mem_addr | output | 32 | Address for the memory access |
| wb_val | output | 32 | Value for the base register writeback |
| wb_en | output | 1 | Base register writeback enable |

## Verification
The bench goes after sums that wrap past 2^32 in both directions. A design that kept a carry or sign-extended the difference would return a wrong address there. It also drives a register offset shifted by 31 and by 0: a shifter that rotated or clamped the amount would leak high bits of the index or drop the offset. It pairs post-indexing with the writeback bit clear, and pre-indexing with base register 15 and writeback set. Here a design that mixed up the two writeback rules would raise or drop `wb_en` in the wrong case. Words whose class bits are not 01 check that the outputs hold and that no valid pulse appears.

// File: rtl/ls_addr_pkg.sv
package ls_addr_pkg;
    localparam int unsigned XLEN    = 32;
    localparam int unsigned IMM_W   = 12;
    localparam int unsigned SH_W    = 5;
    localparam int unsigned RIDX_W  = 4;
    localparam int unsigned PC_IDX  = 15;

    // bit positions the decoder depends on
    localparam int unsigned CLS_HI  = 27;
    localparam int unsigned CLS_LO  = 26;
    localparam int unsigned REG_BIT = 25;
    localparam int unsigned PRE_BIT = 24;
    localparam int unsigned UP_BIT  = 23;
    localparam int unsigned WB_BIT  = 21;
    localparam int unsigned RN_LO   = 16;
    localparam int unsigned SH_LO   = 7;
    localparam logic [1:0]  LS_CLASS = 2'b01;

    typedef struct packed {
        logic              is_ls;
        logic              reg_ofs;
        logic              pre;
        logic              up;
        logic              wb;
        logic [RIDX_W-1:0] rn;
        logic [IMM_W-1:0]  imm;
        logic [SH_W-1:0]   shamt;
    } ls_ctrl_t;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] wbv;
        logic            wen;
    } ls_out_t;
endpackage

// File: rtl/ls_field_dec.sv
module ls_field_dec
    import ls_addr_pkg::*;
(
    input  logic [XLEN-1:0] insn,
    output ls_ctrl_t        ctl
);
    logic unused_fields;
    assign unused_fields = ^{insn[31:28], insn[22], insn[20], insn[15:12]};

    always_comb begin
        ctl.is_ls   = (insn[CLS_HI:CLS_LO] == LS_CLASS);
        ctl.reg_ofs = insn[REG_BIT];
        ctl.pre     = insn[PRE_BIT];
        ctl.up      = insn[UP_BIT];
        ctl.wb      = insn[WB_BIT];
        ctl.rn      = insn[RN_LO +: RIDX_W];
        ctl.imm     = insn[IMM_W-1:0];
        ctl.shamt   = insn[SH_LO +: SH_W];
    end
endmodule

// File: rtl/ls_offset_sel.sv
module ls_offset_sel
    import ls_addr_pkg::*;
(
    input  ls_ctrl_t        ctl,
    input  logic [XLEN-1:0] idx_val,
    output logic [XLEN-1:0] offset
);
    localparam int unsigned STAGES = SH_W;

    logic [XLEN-1:0] stage [STAGES+1];

    assign stage[0] = idx_val;

    // logarithmic left shifter, one stage per shift-amount bit
    for (genvar s = 0; s < STAGES; s++) begin : g_shift
        assign stage[s+1] = ctl.shamt[s] ? {stage[s][XLEN-1-(1<<s):0], {(1<<s){1'b0}}}
                                         : stage[s];
    end

    always_comb begin
        if (ctl.reg_ofs) offset = stage[STAGES];
        else             offset = {{(XLEN-IMM_W){1'b0}}, ctl.imm};
    end
endmodule

// File: rtl/ls_index_calc.sv
module ls_index_calc
    import ls_addr_pkg::*;
(
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] offset,
    input  logic            up,
    output logic [XLEN-1:0] adjusted
);
    logic [XLEN-1:0] operand;

    always_comb begin
        // subtraction as base + ~offset + 1, sharing one adder
        operand  = up ? offset : ~offset;
        adjusted = base + operand + {{(XLEN-1){1'b0}}, ~up};
    end
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
    import ls_addr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] insn,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] idx_val,
    output logic            out_valid,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] wb_val,
    output logic            wb_en
);
    localparam logic [RIDX_W-1:0] PC_NUM = RIDX_W'(PC_IDX);

    ls_ctrl_t        ctl;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] adjusted;
    ls_out_t         res_d, res_q;

    ls_field_dec u_dec (
        .insn (insn),
        .ctl  (ctl)
    );

    ls_offset_sel u_ofs (
        .ctl     (ctl),
        .idx_val (idx_val),
        .offset  (offset)
    );

    ls_index_calc u_calc (
        .base     (base_val),
        .offset   (offset),
        .up       (ctl.up),
        .adjusted (adjusted)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid && ctl.is_ls;
        if (res_d.vld) begin
            res_d.wbv = adjusted;
            if (ctl.pre) begin
                res_d.addr = adjusted;
                res_d.wen  = ctl.wb && (ctl.rn != PC_NUM);
            end else begin
                res_d.addr = base_val;
                res_d.wen  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign mem_addr  = res_q.addr;
    assign wb_val    = res_q.wbv;
    assign wb_en     = res_q.wen;

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[CLS_HI:CLS_LO] == LS_CLASS) |=> out_valid);

    // R2
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && insn[CLS_HI:CLS_LO] == LS_CLASS) |=> !out_valid);

    // R6
    post_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[CLS_HI:CLS_LO] == LS_CLASS && !insn[PRE_BIT])
        |=> (mem_addr == $past(base_val) && wb_en));

    // R7
    pc_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[CLS_HI:CLS_LO] == LS_CLASS && insn[PRE_BIT]
         && insn[RN_LO +: RIDX_W] == PC_NUM) |=> !wb_en);

    // R5
    pre_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[CLS_HI:CLS_LO] == LS_CLASS && insn[PRE_BIT])
        |=> (mem_addr == wb_val));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && insn[CLS_HI:CLS_LO] == LS_CLASS)
        |=> ($stable(mem_addr) && $stable(wb_val) && $stable(wb_en)));
endmodule

// File: tb/tb_ls_addr_gen.sv
module tb_ls_addr_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] base_val = '0;
    logic [31:0] idx_val = '0;
    logic        out_valid;
    logic [31:0] mem_addr;
    logic [31:0] wb_val;
    logic        wb_en;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [31:0] last_addr = '0;
    logic [31:0] last_wbv = '0;
    logic        last_wen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ls_addr_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .insn      (insn),
        .base_val  (base_val),
        .idx_val   (idx_val),
        .out_valid (out_valid),
        .mem_addr  (mem_addr),
        .wb_val    (wb_val),
        .wb_en     (wb_en)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit [1:0] cls, bit i, bit p, bit u, bit w,
                                       bit [3:0] rn, bit [11:0] lo);
        return {4'hE, cls, i, p, u, 1'b0, w, 1'b0, rn, 4'h0, lo};
    endfunction

    function automatic void model(logic [31:0] iw, logic [31:0] b, logic [31:0] x,
                                  output logic [31:0] a, output logic [31:0] v,
                                  output logic e);
        logic [31:0] ofs;
        logic [31:0] adj;
        ofs = iw[25] ? (x << iw[11:7]) : {20'd0, iw[11:0]};
        adj = iw[23] ? b + ofs : b - ofs;
        v = adj;
        if (iw[24]) begin
            a = adj;
            e = iw[21] && (iw[19:16] != 4'd15);
        end else begin
            a = b;
            e = 1'b1;
        end
    endfunction

    task automatic send(string req, logic [31:0] iw, logic [31:0] b, logic [31:0] x);
        logic [31:0] ea, ev;
        logic ee;
        bit acc;
        acc = (iw[27:26] == 2'b01);
        @(negedge clk);
        insn = iw; base_val = b; idx_val = x; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (acc) begin
            model(iw, b, x, ea, ev, ee);
            last_addr = ea; last_wbv = ev; last_wen = ee;
            check({req, " R2 valid"}, {31'd0, out_valid}, 32'd1);
        end else begin
            check({req, " R2 no valid"}, {31'd0, out_valid}, 32'd0);
        end
        check({req, " addr"}, mem_addr, last_addr);
        check({req, " wbval"}, wb_val, last_wbv);
        check({req, " wben"}, {31'd0, wb_en}, {31'd0, last_wen});
        if (acc) begin
            @(negedge clk);
            check({req, " R2 single pulse"}, {31'd0, out_valid}, 32'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd20417);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 wben", {31'd0, wb_en}, 32'd0);
        check("R1 addr", mem_addr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {31'd0, out_valid}, 32'd0);

        // R5 pre, no writeback, immediate add
        send("R5 R3 pre imm", mk(2'b01, 0, 1, 1, 0, 4'd5, 12'd25), 32'h100, 32'h0);
        // R5 pre writeback, register offset shifted by 2
        send("R5 R3 pre reg", mk(2'b01, 1, 1, 1, 1, 4'd5, {5'd2, 7'd0}), 32'h1000, 32'd3);
        // R6 post, subtract, writeback bit clear
        send("R6 R4 post sub", mk(2'b01, 0, 0, 0, 0, 4'd2, 12'h010), 32'h40, 32'h0);
        // R7 base 15 with pre writeback
        send("R7 pc guard", mk(2'b01, 0, 1, 1, 1, 4'd15, 12'd8), 32'h2000, 32'h0);
        // R6 post with base 15 still writes back
        send("R6 post pc", mk(2'b01, 0, 0, 1, 1, 4'd15, 12'd4), 32'h3000, 32'h0);
        // R4 wrap on add and on subtract
        send("R4 wrap add", mk(2'b01, 0, 1, 1, 1, 4'd1, 12'h020), 32'hFFFF_FFF0, 32'h0);
        send("R4 wrap sub", mk(2'b01, 0, 1, 0, 1, 4'd1, 12'hFFF), 32'h0000_0010, 32'h0);
        // R3 shift by 31 and by 0
        send("R3 shift31", mk(2'b01, 1, 1, 1, 1, 4'd3, {5'd31, 7'd0}), 32'h10, 32'hFFFF_FFFF);
        send("R3 shift0", mk(2'b01, 1, 0, 0, 0, 4'd3, 12'd0), 32'h500, 32'h123);
        // R8 words of another class are ignored
        send("R8 class00", mk(2'b00, 0, 1, 1, 1, 4'd4, 12'd99), 32'h7777, 32'h1);
        send("R8 class10", mk(2'b10, 1, 0, 0, 1, 4'd4, 12'd1), 32'h8888, 32'h2);

        for (int n = 0; n < 300; n++) begin
            logic [31:0] iw;
            iw = $urandom;
            if ($urandom % 4 != 0) iw[27:26] = 2'b01;
            if ($urandom % 8 == 0) iw[19:16] = 4'd15;
            send("R3 R4 R5 R6 R7 R8 random", iw, $urandom, $urandom);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule